// File: doc/BRIEF.md
# Dual-Channel Shared-Period PWM Generator

This block is a pulse-width modulation timer with two output channels that share one timebase. A power-of-two prescaler, chosen by a 3-bit code, divides the enabled clock into ticks. A 16-bit counter counts those ticks from zero up to the modulo value minus one and then wraps. Each channel compares the shared count against its own 16-bit duty value and drives its pin to the active level while the count is below the duty. A per-channel polarity bit chooses whether the active level is high or low. The duty is saturating. A duty of zero keeps the pin at its idle level. A duty at or above the modulo keeps the pin at its active level.

Software loads the settings through a simple write port. Duty and modulo writes go into shadow registers and are copied into the working registers only when the counter wraps, so a period is never cut short and no runt pulse appears. Prescale and polarity writes take effect at once. At each wrap the block raises a one-cycle period-end strobe, which other logic can use as a regular sample tick.

Top module: `dual_pwm_timer`

## Requirements
- R1: The prescale code `ps` (address 0, bits [2:0]) sets one counter tick to 2^ps enabled clock cycles, so one period lasts modulo × 2^ps cycles.
- R2: The modulo (address 1) sets the number of ticks in one period. The counter runs 0 … modulo−1 and then wraps to 0.
- R3: A channel whose duty is 0 stays at its idle level for the whole period.
- R4: A channel whose duty is greater than or equal to the modulo stays at its active level for the whole period.
- R5: A channel whose duty d satisfies 0 < d < modulo is active for the first d ticks of each period and idle for the rest.
- R6: The polarity bit of channel i (address 0, bit 8+i) chooses the levels. With 0 the active level is high and idle is low. With 1 the active level is low and idle is high. The change applies at once.
- R7: Both channels share one prescaler, counter and modulo. Channel i takes its own duty from address 2+i.
- R8: A duty or modulo write made in the middle of a period leaves that period unchanged. The new value first applies in the period that begins at the next wrap.
- R9: `period_end` is high for exactly one clock cycle at each wrap. That cycle is the first cycle of the new period, in which the count is 0.
- R10: After reset, the count, duty values, modulo, prescale and polarity are all zero, both pins are low (idle), and `period_end` is low.
- R11: While `clk_en` is low, the prescaler, counter, pins and strobe hold their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Count enable for the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 modulo, 2 duty ch0, 3 duty ch1 |
| wr_data | input | 16 | Write data |
| pwm_out | output | 2 | Channel pin levels, bit i is channel i |
| period_end | output | 1 | One-cycle strobe at each counter wrap |

## Verification
Several properties are checked on every clock cycle. The count stays below a non-zero modulo. The strobe only occurs when the count is zero. Working duty and modulo values change only at a wrap. Nothing advances without a tick. A zero duty always gives the idle level, and a saturated duty always gives the active level. Exact pulse widths, period lengths in clock cycles across prescale settings, polarity inversion, the two channels sharing a period, and the "current period unaffected" outcome of a mid-period write can only be shown by the bench, which measures whole periods at the pins.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    // Register address codes
    localparam int ADDR_CTRL      = 0;
    localparam int ADDR_MOD       = 1;
    localparam int ADDR_DUTY_BASE = 2;
    // Control word layout: prescale code in the low bits, polarity of channel i at POL_LSB+i
    localparam int POL_LSB        = 8;
    // Defaults
    localparam int DEF_CNT_W      = 16;
    localparam int DEF_PS_W       = 3;
    localparam int DEF_NCH        = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clk_en,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_q, pre_d;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int k = 0; k < DIV_W; k++) begin
            mask[k] = (PS_W'(k) < ps);
        end
        tick  = clk_en && ((pre_q & mask) == mask);
        pre_d = clk_en ? pre_q + DIV_W'(1) : pre_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R11: the divider holds while the enable is low
    a_r11_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pre_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mod_we,
    input  logic [CNT_W-1:0] mod_wdata,
    output logic [CNT_W-1:0] cnt_nx,
    output logic [CNT_W-1:0] mod_nx,
    output logic [CNT_W-1:0] mod_cur,
    output logic             load,
    output logic             period_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] mod_act;
        logic [CNT_W-1:0] mod_shd;
        logic             strobe;
    } tb_state_t;

    tb_state_t s_q, s_d;
    logic      wrap;

    always_comb begin
        s_d      = s_q;
        wrap     = ({1'b0, s_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, s_q.mod_act};
        if (mod_we) s_d.mod_shd = mod_wdata;
        s_d.strobe = 1'b0;
        if (tick) begin
            if (wrap) begin
                s_d.cnt     = '0;
                s_d.mod_act = s_q.mod_shd;
                s_d.strobe  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
        load       = tick && wrap;
        cnt_nx     = s_d.cnt;
        mod_nx     = s_d.mod_act;
        mod_cur    = s_q.mod_act;
        period_end = s_q.strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the count never reaches a non-zero modulo
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mod_act != '0) |-> (s_q.cnt < s_q.mod_act));
    // R9: the strobe marks the first cycle of a period
    a_r9_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.strobe |-> (s_q.cnt == '0));
    // R11: no tick, no movement
    a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(s_q.cnt) && $stable(s_q.mod_act) && !s_q.strobe));
    // R8: the working modulo changes only at a wrap
    a_r8_mod_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.mod_act));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [CNT_W-1:0] mod_nx,
    input  logic [CNT_W-1:0] mod_cur,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_we,
    input  logic             pol_wdata,
    output logic             pin
);
    typedef struct packed {
        logic [CNT_W-1:0] duty_act;
        logic [CNT_W-1:0] duty_shd;
        logic             pol;
        logic             pin;
    } ch_state_t;

    ch_state_t s_q, s_d;
    logic      active_d;

    always_comb begin
        s_d = s_q;
        if (duty_we) s_d.duty_shd = duty_wdata;
        if (pol_we)  s_d.pol      = pol_wdata;
        if (load)    s_d.duty_act = s_q.duty_shd;
        // saturating compare: zero never active, duty >= modulo always active
        active_d = (s_d.duty_act != '0) &&
                   ((s_d.duty_act >= mod_nx) || (cnt_nx < s_d.duty_act));
        s_d.pin  = active_d ^ s_d.pol;
        pin      = s_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: zero duty keeps the idle level
    a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.duty_act == '0) |-> (s_q.pin == s_q.pol));
    // R4: saturated duty keeps the active level
    a_r4_full_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.duty_act != '0) && (s_q.duty_act >= mod_cur)) |-> (s_q.pin != s_q.pol));
    // R8: the working duty changes only at a wrap
    a_r8_duty_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q.duty_act));
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int PS_W   = DEF_PS_W,
    parameter int NCH    = DEF_NCH,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic              period_end
);
    typedef struct packed {
        logic [PS_W-1:0] ps;
    } ctrl_t;

    ctrl_t            ctrl_q, ctrl_d;
    logic             ctrl_we, mod_we, tick, load;
    logic [CNT_W-1:0] cnt_nx, mod_nx, mod_cur;

    always_comb begin
        ctrl_we = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        mod_we  = wr_en && (wr_addr == ADDR_W'(ADDR_MOD));
        ctrl_d  = ctrl_q;
        if (ctrl_we) ctrl_d.ps = wr_data[PS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    pwm_prescaler #(.PS_W(PS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .ps     (ctrl_q.ps),
        .tick   (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mod_we     (mod_we),
        .mod_wdata  (wr_data),
        .cnt_nx     (cnt_nx),
        .mod_nx     (mod_nx),
        .mod_cur    (mod_cur),
        .load       (load),
        .period_end (period_end)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic duty_we;
        assign duty_we = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY_BASE + i));

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .cnt_nx     (cnt_nx),
            .mod_nx     (mod_nx),
            .mod_cur    (mod_cur),
            .duty_we    (duty_we),
            .duty_wdata (wr_data),
            .pol_we     (ctrl_we),
            .pol_wdata  (wr_data[POL_LSB+i]),
            .pin        (pwm_out[i])
        );
    end

    // R10: strobe and pins are low while reset is applied
    always_comb begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!period_end && (pwm_out == '0));
        end
    end
endmodule

// File: tb/tb_dual_pwm_timer.sv
module tb_dual_pwm_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    // ps, modulo, duty0, duty1, pol0, pol1
    localparam int VEC [NVEC][6] = '{
        '{0, 10,  3,     7, 0, 0},
        '{1,  8,  0,     8, 0, 0},
        '{2,  6,  6,     2, 1, 0},
        '{3,  5,  9,     1, 0, 1},
        '{0, 16, 15,     1, 1, 1},
        '{7,  3,  1,     2, 0, 0},
        '{4, 12, 12,     0, 1, 1},
        '{0,  2,  1, 65535, 0, 0}
    };

    logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pwm_out;
    logic        period_end;
    int tests = 0, fails = 0;

    dual_pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .period_end(period_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync();
        int n = 0;
        do begin @(negedge clk); n++; end while (!period_end && n < 5000);
    endtask

    task automatic measure(output int len, output int h0, output int h1);
        len = 0; h0 = 0; h1 = 0;
        do begin
            h0 += int'(pwm_out[0]); h1 += int'(pwm_out[1]); len++;
            @(negedge clk);
        end while (!period_end && len < 5000);
    endtask

    function automatic int high_cycles(int ps, int m, int d, int pol);
        int act = (d == 0) ? 0 : ((d >= m) ? m : d);
        act = act << ps;
        return pol != 0 ? (m << ps) - act : act;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int len, h0, h1, cyc, stray;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 pins in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 pins after reset", int'(pwm_out), 0);
        check("R10 strobe after reset", int'(period_end), 0);
        clk_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R3 zero duty idle after reset", int'(pwm_out), 0);

        // Table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            wr(0, VEC[v][0] | (VEC[v][4] << 8) | (VEC[v][5] << 9));
            wr(1, VEC[v][1]);
            wr(2, VEC[v][2]);
            wr(3, VEC[v][3]);
            sync(); sync();
            measure(len, h0, h1);
            check($sformatf("R1 R2 period vec%0d", v), len, VEC[v][1] << VEC[v][0]);
            check($sformatf("R5 R6 ch0 high cycles vec%0d", v), h0,
                  high_cycles(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][4]));
            check($sformatf("R7 R4 R3 ch1 high cycles vec%0d", v), h1,
                  high_cycles(VEC[v][0], VEC[v][1], VEC[v][3], VEC[v][5]));
        end

        // R11: freeze with the enable low
        wr(0, 0); wr(1, 10); wr(2, 4); wr(3, 0);
        sync(); sync();
        clk_en = 1'b0;
        stray = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (pwm_out != 2'b01 || period_end) stray++;
        end
        check("R11 frozen outputs", stray, 0);
        clk_en = 1'b1;

        // R8: mid-period duty and modulo writes
        wr(2, 2); wr(3, 2);
        sync(); sync();
        cyc = 0; stray = 0;
        for (int k = 0; k < 3; k++) begin @(negedge clk); cyc++; end
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd8;
        @(negedge clk); cyc++;
        wr_addr = 2'd1; wr_data = 16'd20;
        @(negedge clk); cyc++;
        wr_en = 1'b0;
        while (!period_end && cyc < 100) begin
            if (pwm_out[0]) stray++;
            @(negedge clk); cyc++;
        end
        check("R8 current period length kept", cyc, 10);
        check("R8 no early duty change", stray, 0);
        measure(len, h0, h1);
        check("R8 new modulo next period", len, 20);
        check("R8 new duty next period", h0, 8);
        check("R7 ch1 unchanged on shared period", h1, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule